// File: doc/BRIEF.md
# Pulse-Width Symbol and Gap Receiver

This block receives a serial stream in which each digit is sent as two high pulses, each short or long. It brings the line into the local clock domain and classifies each high pulse from a single sample. That sample is taken a fixed number of local ticks after the pulse's rising edge. If the line is still high at that point, the pulse is long. If the line is already low, the pulse is short. Consecutive pulses are paired into one of three digit values: zero, one or open.

The block also times how long the line stays low. A moderate low stretch marks the end of a word. A longer stretch marks the end of the whole transmission. Every transition of the line restarts that timing. Each gap strobe fires at most once per idle stretch, and only after a rising edge has been seen. The end-of-word strobe also discards a half-received pair, so the next word always starts on the first pulse of a pair.

A downstream word assembler consumes the digit strobes and the two gap strobes. All timing values are parameters expressed in local clock ticks.

Top module: `pulse_symbol_rx`

## Requirements
- R1: A high pulse longer than SAMPLE_DLY ticks is classified long, and one shorter than SAMPLE_DLY ticks is classified short. The decision uses the single line sample taken SAMPLE_DLY ticks after the synchronized rising edge.
- R2: A short pulse followed by a short pulse yields a digit zero, reported as digit_o = 2'b00.
- R3: Long followed by long yields a digit one, reported as 2'b01. Long followed by short yields open, reported as 2'b10. The code 2'b11 is never reported.
- R4: Short followed by long is illegal. It raises err_o for one cycle, reports no digit and clears the pair state, so the next pulse starts a new pair.
- R5: digit_vld_o and err_o are single-cycle strobes, and they are never high together.
- R6: eow_o pulses once after the synchronized line has stayed low for EOW_TICKS ticks. Every transition restarts that count, so low stretches shorter than EOW_TICKS produce no strobe.
- R7: eot_o pulses once after the line has stayed low for EOT_TICKS ticks (EOT_TICKS > EOW_TICKS). In the same low stretch, eow_o always comes first.
- R8: eow_o and eot_o each fire at most once per idle stretch. Neither fires again until a new rising edge is seen, and neither fires after reset before the first rising edge.
- R9: eow_o clears a half-received pair. A lone pulse followed by an end-of-word gap does not combine with the next pulse.
- R10: While rst_ni is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial pulse line (asynchronous to clk_i) |
| digit_vld_o | output | 1 | Digit strobe |
| digit_o | output | 2 | Digit code: 00 zero, 01 one, 10 open |
| err_o | output | 1 | Illegal pair strobe (short then long) |
| eow_o | output | 1 | End-of-word strobe |
| eot_o | output | 1 | End-of-transmission strobe |

## Verification
The bench sends random words with random inter-pulse gaps. It then goes after the edge cases:
- Pulse widths just two ticks either side of the sample point. A sampler off by a few ticks would swap long and short.
- An illegal short-long pair followed by a legal digit. A decoder that failed to clear its pair state would misalign every following digit.
- A lone pulse followed by a word gap. Without the flush, the leftover pulse would pair with the next word's first pulse and give open instead of zero.
- Long idle periods, both from reset and after a transmission. These expose gap strobes that repeat or that fire without a preceding rising edge.

// File: rtl/pulse_rx_pkg.sv
package pulse_rx_pkg;
  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_ONE  = 2'b01,
    DIG_OPEN = 2'b10
  } digit_e;
endpackage

// File: rtl/prx_sync.sv
module prx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/prx_width_sampler.sv
module prx_width_sampler #(
  parameter int unsigned SAMPLE_DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic rise_i,
  output logic sym_vld_o,
  output logic sym_long_o
);
  localparam int unsigned CW = $clog2(SAMPLE_DLY + 1);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(SAMPLE_DLY);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (rise_i) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(1);
    end else if (active_q) begin
      if (cnt_q == SAMPLE_AT) active_q <= 1'b0;
      else                    cnt_q    <= cnt_q + CW'(1);
    end
  end

  // one delayed sample decides the width
  assign sym_vld_o  = active_q && (cnt_q == SAMPLE_AT);
  assign sym_long_o = line_i;

  AST_SAMPLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o); // R5
  AST_SAMPLE_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !sym_vld_o); // R1
endmodule

// File: rtl/prx_pair_decoder.sv
module prx_pair_decoder
  import pulse_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_vld_i,
  input  logic       sym_long_i,
  input  logic       flush_i,
  output logic       digit_vld_o,
  output logic [1:0] digit_o,
  output logic       err_o
);
  logic   half_q, first_long_q;
  digit_e digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q       <= 1'b0;
      first_long_q <= 1'b0;
      digit_vld_o  <= 1'b0;
      err_o        <= 1'b0;
      digit_q      <= DIG_ZERO;
    end else begin
      digit_vld_o <= 1'b0;
      err_o       <= 1'b0;
      if (flush_i) begin
        half_q <= 1'b0;
      end else if (sym_vld_i) begin
        if (!half_q) begin
          half_q       <= 1'b1;
          first_long_q <= sym_long_i;
        end else begin
          half_q <= 1'b0;
          if (!first_long_q && sym_long_i) begin
            err_o <= 1'b1;
          end else begin
            digit_vld_o <= 1'b1;
            if (!first_long_q)   digit_q <= DIG_ZERO;
            else if (sym_long_i) digit_q <= DIG_ONE;
            else                 digit_q <= DIG_OPEN;
          end
        end
      end
    end
  end

  assign digit_o = digit_q;

  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_vld_o |-> digit_o != 2'b11); // R3
  AST_VLD_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(digit_vld_o && err_o)); // R5
  AST_ERR_PAIR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !half_q); // R4
  AST_FLUSH_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !half_q); // R9
endmodule

// File: rtl/prx_gap_timer.sv
module prx_gap_timer #(
  parameter int unsigned EOW_TICKS = 64,
  parameter int unsigned EOT_TICKS = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_i,
  input  logic rise_i,
  output logic eow_o,
  output logic eot_o
);
  localparam int unsigned GW = $clog2(EOT_TICKS + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(EOT_TICKS);
  localparam logic [GW-1:0] EOW_AT  = GW'(EOW_TICKS - 1);
  localparam logic [GW-1:0] EOT_AT  = GW'(EOT_TICKS - 1);

  logic [GW-1:0] gap_q;
  logic          eow_arm_q, eot_arm_q;
  logic          quiet, eow_hit, eot_hit;

  assign quiet   = !line_i && !edge_i;
  assign eow_hit = eow_arm_q && quiet && (gap_q == EOW_AT);
  assign eot_hit = eot_arm_q && quiet && (gap_q == EOT_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      eow_arm_q <= 1'b0;
      eot_arm_q <= 1'b0;
      eow_o     <= 1'b0;
      eot_o     <= 1'b0;
    end else begin
      if (!quiet)                gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + GW'(1);
      // arms re-open only on a new rising edge
      if (rise_i)       eow_arm_q <= 1'b1;
      else if (eow_hit) eow_arm_q <= 1'b0;
      if (rise_i)       eot_arm_q <= 1'b1;
      else if (eot_hit) eot_arm_q <= 1'b0;
      eow_o <= eow_hit;
      eot_o <= eot_hit;
    end
  end

  AST_EOW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eow_o |=> !eow_o); // R8
  AST_EOT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_o |=> !eot_o); // R8
  AST_EOW_BEFORE_EOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_o |-> !eow_arm_q); // R7
  AST_GAP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> gap_q == '0); // R6
endmodule

// File: rtl/pulse_symbol_rx.sv
module pulse_symbol_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SAMPLE_DLY  = 8,
  parameter int unsigned EOW_TICKS   = 64,
  parameter int unsigned EOT_TICKS   = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       digit_vld_o,
  output logic [1:0] digit_o,
  output logic       err_o,
  output logic       eow_o,
  output logic       eot_o
);
  logic line_s, line_d_q, rise, line_edge;
  logic sym_vld, sym_long;

  prx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(line_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) line_d_q <= 1'b0;
    else         line_d_q <= line_s;

  assign rise      = line_s && !line_d_q;
  assign line_edge = line_s ^ line_d_q;

  prx_width_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk_i, .rst_ni, .line_i(line_s), .rise_i(rise),
    .sym_vld_o(sym_vld), .sym_long_o(sym_long)
  );

  prx_pair_decoder u_pair (
    .clk_i, .rst_ni, .sym_vld_i(sym_vld), .sym_long_i(sym_long),
    .flush_i(eow_o), .digit_vld_o, .digit_o, .err_o
  );

  prx_gap_timer #(.EOW_TICKS(EOW_TICKS), .EOT_TICKS(EOT_TICKS)) u_gap (
    .clk_i, .rst_ni, .line_i(line_s), .edge_i(line_edge), .rise_i(rise),
    .eow_o, .eot_o
  );

  AST_EOW_EOT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eow_o && eot_o)); // R7
  AST_EOW_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eow_o |-> $past(!line_s)); // R6
endmodule

// File: tb/pulse_symbol_rx_bench.sv
`timescale 1ns/1ps
module pulse_symbol_rx_bench;
  localparam int SAMPLE_DLY = 8;
  localparam int EOW_TICKS  = 64;
  localparam int EOT_TICKS  = 128;

  logic clk = 1'b0, rst_ni = 1'b0, line = 1'b0;
  logic digit_vld, err, eow, eot;
  logic [1:0] digit;

  always #2 clk = ~clk;

  pulse_symbol_rx #(.SAMPLE_DLY(SAMPLE_DLY), .EOW_TICKS(EOW_TICKS), .EOT_TICKS(EOT_TICKS)) u_pulse_symbol_rx (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line),
    .digit_vld_o(digit_vld), .digit_o(digit), .err_o(err), .eow_o(eow), .eot_o(eot)
  );

  int n_chk = 0, n_fail = 0;
  int dig_log [64];
  int n_dig = 0, n_err = 0, n_eow = 0, n_eot = 0, dbl = 0;
  int short_w = 4, long_w = 12, low_w = 8;
  bit done = 0;
  logic prev_vld = 1'b0;

  always @(negedge clk) begin
    if (digit_vld) begin
      if (n_dig < 64) dig_log[n_dig] = int'(digit);
      n_dig++;
    end
    if (digit_vld && prev_vld) dbl++;
    prev_vld = digit_vld;
    if (err) n_err++;
    if (eow) n_eow++;
    if (eot) n_eot++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit lng);
    line = 1'b1;
    idle(lng ? long_w : short_w);
    line = 1'b0;
    idle(low_w);
  endtask

  function automatic int code_of(input int d);
    return (d == 0) ? 0 : (d == 1) ? 1 : 2;
  endfunction

  task automatic send_digit(input int d);
    case (d)
      0:       begin pulse(1'b0); pulse(1'b0); end
      1:       begin pulse(1'b1); pulse(1'b1); end
      default: begin pulse(1'b1); pulse(1'b0); end
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int w [9];
    int mism, e0, t0;
    void'($urandom(32'h1234));
    idle(3);
    check(!digit_vld && !err && !eow && !eot && digit == 2'b00, "R10 reset outputs", int'({digit_vld, err, eow, eot}), 0);
    rst_ni = 1'b1;
    idle(EOT_TICKS + 100);
    check(n_eow == 0 && n_eot == 0, "R8 no gap strobe before first rise", n_eow + n_eot, 0);

    // random words
    for (int k = 0; k < 12; k++) begin
      n_dig = 0; e0 = n_eow; t0 = n_eot;
      low_w = $urandom_range(6, 20);
      for (int i = 0; i < 9; i++) begin
        w[i] = $urandom_range(0, 2);
        send_digit(w[i]);
      end
      idle(EOW_TICKS + 16);
      mism = 0;
      for (int i = 0; i < 9; i++) if (dig_log[i] != code_of(w[i])) mism++;
      check(n_dig == 9 && mism == 0, "R2 R3 word digits", mism + 100 * (n_dig - 9), 0);
      check(n_eow == e0 + 1, "R6 one eow per word", n_eow - e0, 1);
      check(n_eot == t0, "R7 no eot at word gap", n_eot - t0, 0);
    end
    low_w = 8;
    check(n_err == 0, "R4 no error on legal pairs", n_err, 0);
    check(dbl == 0, "R5 digit strobe single cycle", dbl, 0);

    // end of transmission, then long idle
    e0 = n_eow; t0 = n_eot;
    idle(EOT_TICKS);
    check(n_eot == t0 + 1, "R7 eot after long low", n_eot - t0, 1);
    check(n_eow == e0, "R8 eow not repeated", n_eow - e0, 0);
    idle(3 * EOT_TICKS);
    check(n_eot == t0 + 1, "R8 eot not repeated", n_eot - t0, 1);

    // gaps below EOW inside a word
    e0 = n_eow; n_dig = 0; low_w = EOW_TICKS - 16;
    send_digit(1); send_digit(0); send_digit(2);
    check(n_eow == e0, "R6 short gaps restart timer", n_eow - e0, 0);
    low_w = 8;
    idle(EOW_TICKS + 16);
    check(n_dig == 3 && dig_log[0] == 1 && dig_log[1] == 0 && dig_log[2] == 2, "R6 slow word digits", n_dig, 3);
    check(n_eow == e0 + 1, "R6 eow after slow word", n_eow - e0, 1);

    // near-threshold widths
    n_dig = 0; short_w = SAMPLE_DLY - 2; long_w = SAMPLE_DLY + 2;
    send_digit(1); send_digit(2); send_digit(0);
    idle(EOW_TICKS + 16);
    check(n_dig == 3 && dig_log[0] == 1 && dig_log[1] == 2 && dig_log[2] == 0, "R1 threshold widths", dig_log[1], 2);
    short_w = 4; long_w = 12;

    // illegal pair
    n_dig = 0; n_err = 0;
    pulse(1'b0); pulse(1'b1);
    idle(4);
    check(n_err == 1 && n_dig == 0, "R4 short-long error", n_err, 1);
    send_digit(1);
    check(n_dig == 1 && dig_log[0] == 1, "R4 pair cleared after error", dig_log[0], 1);
    idle(EOW_TICKS + 16);

    // lone pulse flushed by eow
    n_dig = 0; e0 = n_eow;
    pulse(1'b1);
    idle(EOW_TICKS + 16);
    check(n_eow == e0 + 1 && n_dig == 0, "R9 lone pulse gives no digit", n_dig, 0);
    send_digit(0);
    idle(EOW_TICKS + 16);
    check(n_dig == 1 && dig_log[0] == 0, "R9 flush realigns pair", dig_log[0], 0);
    check(n_err == 1, "R5 error strobe single count", n_err, 1);

    finish_run();
  end
endmodule